// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block holds the handshake state for one parallel data port on a peripheral interface. The port runs in one of three modes. In strobed input it latches data from an external device. In strobed output it holds data for the device until the device acknowledges it. In bidirectional mode both handshakes share one pin group. The parent interface block decodes registers and commands. It hands this channel a mode code, two interrupt-enable bits and read and write strobes. It reads back the status flags, which it reports through its own status bits.

On the device side, an active-low strobe loads the input latch. An active-low acknowledge accepts the output latch. Both device signals are asynchronous, so they pass through a synchronizer of configurable depth. The pin data is delayed through a matching pipeline so that the captured word lines up with the strobe edge. An interrupt request can come from either direction. The output drivers are enabled all the time in output mode. In bidirectional mode they are enabled only while the acknowledge is low.

Top module: `hsp_channel`

## Requirements
- R1: After reset, with mode input, ibf=0, obf_n=1, intr=0, rd_data=0 and pin_oe=0.
- R2: In input mode (code 2'b00) a rising edge of stb_n loads pin_in into the input latch, which appears on rd_data, and sets ibf to 1.
- R3: A completed processor read (the cycle rd_en falls) clears ibf.
- R4: A second strobe while ibf=1 overwrites the latch with the new pin data, and ibf stays 1.
- R5: If a strobe capture and a read completion fall in the same cycle, the capture wins: the latch takes the new data and ibf stays 1.
- R6: The input interrupt is set on the stb_n rising edge when ie_in=1, is not set when ie_in=0, and is cleared by read completion.
- R7: In output mode (code 2'b01) a wr_en cycle loads wr_data into the output latch, shown on pin_out, and drives obf_n to 0; pin_oe is 1 in this mode.
- R8: A falling edge of ack_n returns obf_n to 1.
- R9: In output mode, a rising edge of ack_n while obf_n=1 and ie_out=1 sets intr; the next wr_en clears it.
- R10: In bidirectional mode (code 2'b10) pin_oe follows the inverse of ack_n, both handshakes operate, and intr is the OR of both directions.
- R11: In input mode writes are ignored (obf_n stays 1, pin_out unchanged); in output mode strobes are ignored (ibf stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 input, 01 output, 10 bidirectional, 11 treated as input |
| ie_in | input | 1 | Input-direction interrupt enable |
| ie_out | input | 1 | Output-direction interrupt enable |
| rd_en | input | 1 | Processor read level; completion on its falling edge |
| wr_en | input | 1 | Processor write strobe, one cycle |
| wr_data | input | WIDTH | Data written by the processor |
| rd_data | output | WIDTH | Input latch contents |
| stb_n | input | 1 | Device strobe, active low, captures on rise |
| ack_n | input | 1 | Device acknowledge, active low |
| pin_in | input | WIDTH | Pin data from the device |
| pin_out | output | WIDTH | Output latch driven toward the pins |
| pin_oe | output | 1 | Pin output enable |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
A new strobe capture and a processor read completion can land on the same clock edge. One sets the full flag and the other clears it. The bench provokes this by releasing the strobe one cycle before raising the read level, so the two-stage synchronizer delivers the strobe edge on the same cycle the read level falls. It then judges that ibf is still 1 and that rd_data holds the newer word. A write arriving during an acknowledge is the matching case in the output direction; there the write is given priority.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   typedef enum logic [1:0] {
      HSP_IN    = 2'b00,
      HSP_OUT   = 2'b01,
      HSP_BIDIR = 2'b10,
      HSP_RSVD  = 2'b11
   } hsp_mode_e;
endpackage

// File: rtl/hsp_edge_sync.sv
module hsp_edge_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad_stages
      $error("hsp_edge_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sh[0] <= IDLE_VAL;
            else        sh[0] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= IDLE_VAL;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= IDLE_VAL;
      else        prev <= sh[LAST];
   end

   assign level = sh[LAST];
   assign rise  = sh[LAST] & ~prev;
   assign fall  = ~sh[LAST] & prev;
endmodule

// File: rtl/hsp_in_path.sv
module hsp_in_path #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ie,
   input  logic             stb_n,
   input  logic [WIDTH-1:0] pin_in,
   input  logic             rd_en,
   output logic [WIDTH-1:0] latch,
   output logic             ibf,
   output logic             intr
);
   localparam int LAST = STAGES - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("hsp_in_path: WIDTH must be at least 1");
   end

   logic             stb_level;
   logic             stb_rise;
   logic             stb_fall;
   logic [WIDTH-1:0] dpipe [STAGES];
   logic             rd_q;
   logic             rd_done;
   logic             cap;

   hsp_edge_sync #(.STAGES(STAGES), .IDLE_VAL(1'b1)) u_stb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (stb_n),
      .level (stb_level),
      .rise  (stb_rise),
      .fall  (stb_fall)
   );

   for (genvar i = 0; i < STAGES; i++) begin : g_dpipe
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) dpipe[0] <= '0;
            else        dpipe[0] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) dpipe[i] <= '0;
            else        dpipe[i] <= dpipe[i-1];
         end
      end
   end

   assign cap     = stb_rise & active;
   assign rd_done = rd_q & ~rd_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         latch <= '0;
         ibf   <= 1'b0;
         intr  <= 1'b0;
      end else begin
         rd_q <= rd_en;
         if (cap) begin
            latch <= dpipe[LAST];
            ibf   <= 1'b1;
            intr  <= intr | ie;
         end else if (rd_done) begin
            ibf  <= 1'b0;
            intr <= 1'b0;
         end
      end
   end

   AST_STB_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> ibf); // R2
   AST_RD_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !cap) |=> !ibf); // R3
   AST_RD_CLEARS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !cap) |=> !intr); // R6
   AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && rd_done) |=> ibf); // R5
   AST_IDLE_HOLDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(latch)); // R4
   AST_INTR_NEEDS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> ibf); // R6

   logic unused_in;
   assign unused_in = stb_level ^ stb_fall;
endmodule

// File: rtl/hsp_out_path.sv
module hsp_out_path #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ie,
   input  logic             ack_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch,
   output logic             obf_n,
   output logic             intr
);
   if (WIDTH < 1) begin : g_bad_width
      $error("hsp_out_path: WIDTH must be at least 1");
   end

   logic ack_level;
   logic ack_rise;
   logic ack_fall;
   logic wr_ok;

   hsp_edge_sync #(.STAGES(STAGES), .IDLE_VAL(1'b1)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (ack_n),
      .level (ack_level),
      .rise  (ack_rise),
      .fall  (ack_fall)
   );

   assign wr_ok = wr_en & active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch <= '0;
         obf_n <= 1'b1;
         intr  <= 1'b0;
      end else begin
         if (wr_ok) begin
            latch <= wr_data;
            obf_n <= 1'b0;
            intr  <= 1'b0;
         end else begin
            if (ack_fall && active) obf_n <= 1'b1;
            if (ack_rise && active && obf_n && ie) intr <= 1'b1;
         end
      end
   end

   AST_WR_LOWERS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !obf_n); // R7
   AST_ACK_RAISES_OBF: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && active && !wr_ok) |=> obf_n); // R8
   AST_WR_CLEARS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !intr); // R9
   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(latch)); // R11

   logic unused_out;
   assign unused_out = ack_level;
endmodule

// File: rtl/hsp_channel.sv
module hsp_channel #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BIDIR_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             ie_in,
   input  logic             ie_out,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   input  logic             stb_n,
   input  logic             ack_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic             pin_oe,
   output logic             ibf,
   output logic             obf_n,
   output logic             intr
);
   import hsp_pkg::*;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("hsp_channel: SYNC_STAGES must be 1..4");
   end

   hsp_mode_e mode_eff;
   logic      in_active;
   logic      out_active;
   logic      intr_in;
   logic      intr_out;

   if (BIDIR_EN) begin : g_bidir
      assign mode_eff = hsp_mode_e'(mode);
   end else begin : g_no_bidir
      assign mode_eff = (hsp_mode_e'(mode) == HSP_BIDIR) ? HSP_IN : hsp_mode_e'(mode);
   end

   always_comb begin
      in_active  = 1'b0;
      out_active = 1'b0;
      pin_oe     = 1'b0;
      unique case (mode_eff)
         HSP_OUT: begin
            out_active = 1'b1;
            pin_oe     = 1'b1;
         end
         HSP_BIDIR: begin
            in_active  = 1'b1;
            out_active = 1'b1;
            pin_oe     = ~ack_n;
         end
         default: in_active = 1'b1;
      endcase
   end

   hsp_in_path #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (in_active),
      .ie     (ie_in),
      .stb_n  (stb_n),
      .pin_in (pin_in),
      .rd_en  (rd_en),
      .latch  (rd_data),
      .ibf    (ibf),
      .intr   (intr_in)
   );

   hsp_out_path #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (out_active),
      .ie      (ie_out),
      .ack_n   (ack_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .latch   (pin_out),
      .obf_n   (obf_n),
      .intr    (intr_out)
   );

   assign intr = (in_active & intr_in) | (out_active & intr_out);

   AST_BIDIR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_eff == HSP_BIDIR && ack_n) |-> !pin_oe); // R10
   AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_eff == HSP_IN) |-> !pin_oe); // R11
   AST_INTR_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> (intr_in || intr_out)); // R10
endmodule

// File: tb/hsp_channel_tb.sv
`timescale 1ns/1ps
module hsp_channel_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         ie_in = 1'b0, ie_out = 1'b0;
   logic         rd_en = 1'b0, wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         stb_n = 1'b1, ack_n = 1'b1;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_out;
   logic         pin_oe, ibf, obf_n, intr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   hsp_channel #(.WIDTH(W), .SYNC_STAGES(2), .BIDIR_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ie_in(ie_in), .ie_out(ie_out),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .stb_n(stb_n), .ack_n(ack_n), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .ibf(ibf), .obf_n(obf_n), .intr(intr)
   );

   // {ie_in, data, expected intr}
   localparam logic [9:0] VEC [4] = '{
      {1'b1, 8'hA5, 1'b1},
      {1'b0, 8'h3C, 1'b0},
      {1'b1, 8'hFF, 1'b1},
      {1'b0, 8'h00, 1'b0}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [W-1:0] d);
      pin_in = d;
      stb_n = 1'b0; tick(4);
      stb_n = 1'b1; tick(4);
   endtask

   task automatic do_read();
      rd_en = 1'b1; tick(1);
      rd_en = 1'b0; tick(2);
   endtask

   task automatic do_write(input logic [W-1:0] d);
      wr_data = d; wr_en = 1'b1; tick(1);
      wr_en = 1'b0; tick(1);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 ibf", ibf, 0);
      chk("R1 obf_n", obf_n, 1);
      chk("R1 intr", intr, 0);
      chk("R1 rd_data", rd_data, 0);
      chk("R1 pin_oe", pin_oe, 0);

      // R2 / R3 / R6 vector walk in input mode
      for (int i = 0; i < 4; i++) begin
         ie_in = VEC[i][9];
         strobe(VEC[i][8:1]);
         chk("R2 ibf", ibf, 1);
         chk("R2 rd_data", rd_data, VEC[i][8:1]);
         chk("R6 intr set", intr, VEC[i][0]);
         do_read();
         chk("R3 ibf cleared", ibf, 0);
         chk("R6 intr cleared", intr, 0);
      end

      // R4 overwrite while full
      ie_in = 1'b0;
      strobe(8'h11);
      strobe(8'h22);
      chk("R4 ibf", ibf, 1);
      chk("R4 rd_data", rd_data, 8'h22);
      do_read();

      // R5 capture coincides with read completion
      pin_in = 8'h77;
      stb_n = 1'b0; tick(4);
      stb_n = 1'b1; tick(1);
      rd_en = 1'b1; tick(1);
      rd_en = 1'b0; tick(4);
      chk("R5 ibf kept", ibf, 1);
      chk("R5 rd_data", rd_data, 8'h77);
      do_read();

      // R11 write ignored in input mode
      do_write(8'h99);
      chk("R11 obf_n input mode", obf_n, 1);
      chk("R11 pin_out input mode", pin_out, 0);

      // R7 / R8 / R9 output mode
      mode = 2'b01; ie_out = 1'b1; tick(1);
      chk("R7 pin_oe", pin_oe, 1);
      do_write(8'hC3);
      chk("R7 obf_n", obf_n, 0);
      chk("R7 pin_out", pin_out, 8'hC3);
      chk("R9 intr before ack", intr, 0);
      ack_n = 1'b0; tick(4);
      chk("R8 obf_n", obf_n, 1);
      ack_n = 1'b1; tick(4);
      chk("R9 intr after ack", intr, 1);
      do_write(8'h3D);
      chk("R9 intr cleared by write", intr, 0);
      ack_n = 1'b0; tick(4); ack_n = 1'b1; tick(4);
      // R11 strobe ignored in output mode
      strobe(8'h5E);
      chk("R11 ibf output mode", ibf, 0);
      do_write(8'h00);

      // R10 bidirectional
      mode = 2'b10; ie_out = 1'b0; ie_in = 1'b1; tick(1);
      chk("R10 oe released", pin_oe, 0);
      do_write(8'h5A);
      ack_n = 1'b0; #1;
      chk("R10 oe with ack", pin_oe, 1);
      chk("R10 pin_out", pin_out, 8'h5A);
      tick(4);
      chk("R10 obf_n", obf_n, 1);
      ack_n = 1'b1; #1;
      chk("R10 oe after ack", pin_oe, 0);
      tick(4);
      strobe(8'h81);
      chk("R10 ibf", ibf, 1);
      chk("R10 rd_data", rd_data, 8'h81);
      chk("R10 intr from input", intr, 1);
      do_read();
      chk("R10 intr cleared", intr, 0);

      // R1 reset again with pending state
      strobe(8'h42);
      mode = 2'b00;
      rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
      chk("R1 ibf after reset", ibf, 0);
      chk("R1 rd_data after reset", rd_data, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule